// File: doc/BRIEF.md
# CDR Lock-Mode Switchover Controller

This block chooses what a clock-recovery loop follows: the reference clock, while it is being trained, or the incoming serial data, once the loop is close enough in frequency. Two manual override pins let a system force either mode. Force-data wins over force-reference. When neither pin is asserted, an automatic state machine makes the choice. It compares a recovered-clock edge count with the expected count over a fixed window of reference cycles. A loss-of-signal condition sends it back to reference mode.

Everything runs in the reference clock domain. The recovered-clock count arrives as a free-running counter already brought into that domain. The block takes the difference of two samples of it, modulo the counter width, so wrap-around needs no special handling. The tolerance is a threshold in counts per window. The override pins may change at any time, so each one passes through a two-flop synchronizer. The faster manual sequence is to hold force-reference while the loop trains, then assert force-data, which avoids waiting on the automatic windows. The block has no data stream: all pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

Top module: `cdr_lockmode_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode output is reference (lock_to_data_o = 0) and freq_locked_o is 0.
- R2: With only force_ref_i high, both outputs go to 0 on the third rising clock edge after the input changes: two synchronizer stages plus the output register. They stay 0 for as long as the input is held, whatever the rate or signal detect.
- R3: With force_data_i high, both outputs go to 1, with the same three-edge latency. This holds whatever force_ref_i, sig_detect_i and the measured frequency are.
- R4: When both overrides are released, the automatic machine starts again from reference mode with a fresh baseline window. The outputs read 0 three edges after the release, even if data mode was forced before.
- R5: In automatic mode, a window of WIN_LEN reference cycles is good when |Δcount − WIN_LEN·RATE_MULT| ≤ thresh_i, where Δcount is the change of rec_count_i modulo 2^CNT_W. The first window after reset or a restart only records a baseline and gives no verdict.
- R6: From reference mode, the machine moves to data mode after GOOD_WIN (2) consecutive good windows. A single good window is not enough.
- R7: A window outside tolerance sends the machine back to reference mode. In reference mode it also clears the run of good windows.
- R8: While sig_detect_i is low, the machine is held in reference mode from the next clock, and window verdicts are ignored. After the signal returns, GOOD_WIN new good windows are needed.
- R9: In every mode, freq_locked_o equals lock_to_data_o. In automatic mode it is high only in data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| force_ref_i | input | 1 | Asynchronous override: hold the loop on the reference clock |
| force_data_i | input | 1 | Asynchronous override: hold the loop on data; takes precedence |
| sig_detect_i | input | 1 | High while a valid serial signal is present |
| rec_count_i | input | CNT_W | Free-running recovered-clock edge count, in this clock domain |
| thresh_i | input | THR_W | Allowed deviation in counts per window |
| lock_to_data_o | output | 1 | 1 = track data, 0 = track reference |
| freq_locked_o | output | 1 | Frequency-locked status flag |

## Verification
The hardest situation to reach from the pins is a run of good windows broken by one bad window while the machine is still in reference mode. It needs window-exact control of the recovered-count rate. The bench releases reset at a known edge, steps the count at a fixed rate for each window-long stretch, and uses rates far enough apart that a one-cycle misalignment cannot change any verdict. The bench sweeps count rates against thresholds that lie exactly on and next to the tolerance edge, to separate `<=` from `<`. It also drives sig_detect_i low during data mode and checks that the verdicts seen while the signal is low are not counted.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  typedef enum logic {
    MODE_REF  = 1'b0,
    MODE_DATA = 1'b1
  } lock_mode_e;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_REF  = 2'd1,
    OVR_DATA = 2'd2
  } ovr_e;

  // force-data outranks force-reference
  function automatic ovr_e ovr_decode(input logic fref, input logic fdata);
    if (fdata)      return OVR_DATA;
    else if (fref)  return OVR_REF;
    else            return OVR_NONE;
  endfunction

endpackage

// File: rtl/cdr_sync2.sv
module cdr_sync2 #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic stg1, stg2;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg1 <= 1'b0;
        stg2 <= 1'b0;
      end else begin
        stg1 <= d[i];
        stg2 <= stg1;
      end
    end
    assign q[i] = stg2;
  end

endmodule

// File: rtl/cdr_freq_meter.sv
module cdr_freq_meter #(
  parameter int WIN_LEN   = 1024,
  parameter int CNT_W     = 16,
  parameter int RATE_MULT = 1,
  parameter int THR_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] rec_count,
  input  logic [THR_W-1:0] thresh,
  output logic             verdict_v,
  output logic             verdict_ok
);

  localparam int WC_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam logic [WC_W-1:0]  WC_LAST = WC_W'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] EXP_CNT = CNT_W'(WIN_LEN * RATE_MULT);

  logic [WC_W-1:0]  wcnt;
  logic [CNT_W-1:0] base_q;
  logic             primed;
  logic [CNT_W-1:0] delta, dev;
  logic             in_tol;
  logic             win_end;

  assign win_end = (wcnt == WC_LAST);
  assign delta   = rec_count - base_q;
  assign dev     = (delta >= EXP_CNT) ? (delta - EXP_CNT) : (EXP_CNT - delta);
  assign in_tol  = (dev <= CNT_W'(thresh));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wcnt       <= '0;
      base_q     <= '0;
      primed     <= 1'b0;
      verdict_v  <= 1'b0;
      verdict_ok <= 1'b0;
    end else begin
      verdict_v <= 1'b0;
      if (win_end) begin
        wcnt   <= '0;
        base_q <= rec_count;
        primed <= 1'b1;
        if (primed) begin
          verdict_v  <= 1'b1;
          verdict_ok <= in_tol;
        end
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  // R5: one verdict per window, never back to back
  p_verdict_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_v |=> !verdict_v);

  // R4: a restart silences the verdict stream
  p_clear_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !verdict_v);

endmodule

// File: rtl/cdr_auto_fsm.sv
module cdr_auto_fsm
  import cdr_lock_pkg::*;
#(
  parameter int GOOD_WIN = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sig_det,
  input  logic       verdict_v,
  input  logic       verdict_ok,
  output lock_mode_e auto_mode
);

  localparam int GC_W = $clog2(GOOD_WIN + 1);
  localparam logic [GC_W-1:0] GC_LAST = GC_W'(GOOD_WIN - 1);

  lock_mode_e      state;
  logic [GC_W-1:0] good_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      state    <= MODE_REF;
      good_cnt <= '0;
    end else if (!sig_det) begin
      state    <= MODE_REF;
      good_cnt <= '0;
    end else if (verdict_v) begin
      if (!verdict_ok) begin
        state    <= MODE_REF;
        good_cnt <= '0;
      end else if (state == MODE_REF) begin
        if (good_cnt == GC_LAST) begin
          state    <= MODE_DATA;
          good_cnt <= '0;
        end else begin
          good_cnt <= good_cnt + 1'b1;
        end
      end
    end
  end

  assign auto_mode = state;

  // R8: loss of signal forces reference on the next clock
  p_sig_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_det |=> (state == MODE_REF));

  // R7: an out-of-tolerance window always lands in reference mode
  p_bad_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_v && !verdict_ok) |=> (state == MODE_REF));

  // R6: reference mode is left only on a verdict
  p_need_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_REF && !verdict_v) |=> (state == MODE_REF));

  // R4: restart lands in reference mode
  p_restart_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (state == MODE_REF));

endmodule

// File: rtl/cdr_lockmode_ctrl.sv
module cdr_lockmode_ctrl
  import cdr_lock_pkg::*;
#(
  parameter int WIN_LEN   = 1024,
  parameter int CNT_W     = 16,
  parameter int RATE_MULT = 1,
  parameter int THR_W     = 12,
  parameter int GOOD_WIN  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_ref_i,
  input  logic             force_data_i,
  input  logic             sig_detect_i,
  input  logic [CNT_W-1:0] rec_count_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             lock_to_data_o,
  output logic             freq_locked_o
);

  logic [1:0] ovr_raw, ovr_sync;
  ovr_e       ovr;
  logic       auto_hold;
  logic       vld, vok;
  lock_mode_e auto_mode;
  lock_mode_e mode_q;
  logic       locked_q;

  assign ovr_raw = {force_data_i, force_ref_i};

  cdr_sync2 #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ovr_raw),
    .q     (ovr_sync)
  );

  assign ovr       = ovr_decode(ovr_sync[0], ovr_sync[1]);
  assign auto_hold = (ovr != OVR_NONE);

  cdr_freq_meter #(
    .WIN_LEN   (WIN_LEN),
    .CNT_W     (CNT_W),
    .RATE_MULT (RATE_MULT),
    .THR_W     (THR_W)
  ) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (auto_hold),
    .rec_count  (rec_count_i),
    .thresh     (thresh_i),
    .verdict_v  (vld),
    .verdict_ok (vok)
  );

  cdr_auto_fsm #(.GOOD_WIN(GOOD_WIN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (auto_hold),
    .sig_det    (sig_detect_i),
    .verdict_v  (vld),
    .verdict_ok (vok),
    .auto_mode  (auto_mode)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_REF;
      locked_q <= 1'b0;
    end else begin
      unique case (ovr)
        OVR_DATA: begin
          mode_q   <= MODE_DATA;
          locked_q <= 1'b1;
        end
        OVR_REF: begin
          mode_q   <= MODE_REF;
          locked_q <= 1'b0;
        end
        default: begin
          mode_q   <= auto_mode;
          locked_q <= (auto_mode == MODE_DATA);
        end
      endcase
    end
  end

  assign lock_to_data_o = (mode_q == MODE_DATA);
  assign freq_locked_o  = locked_q;

  // R3: forced data drives both outputs high
  p_force_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == OVR_DATA) |=> (lock_to_data_o && freq_locked_o));

  // R2: forced reference drives both outputs low
  p_force_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == OVR_REF) |=> (!lock_to_data_o && !freq_locked_o));

  // R4: without overrides the outputs follow the automatic machine
  p_auto_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr == OVR_NONE) |=> (lock_to_data_o == ($past(auto_mode) == MODE_DATA)));

  // R9: status flag agrees with the mode select
  p_flag_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freq_locked_o == lock_to_data_o);

endmodule

// File: tb/sim_cdr_lockmode_ctrl.sv
module sim_cdr_lockmode_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WIN  = 16;
  localparam int CW   = 12;
  localparam int MULT = 4;
  localparam int TW   = 8;
  localparam int GOOD = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          f_ref, f_data, sig;
  logic [CW-1:0] rec;
  logic [TW-1:0] thr;
  logic          l2d, flk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdr_lockmode_ctrl #(
    .WIN_LEN(WIN), .CNT_W(CW), .RATE_MULT(MULT), .THR_W(TW), .GOOD_WIN(GOOD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .force_ref_i(f_ref), .force_data_i(f_data),
    .sig_detect_i(sig), .rec_count_i(rec), .thresh_i(thr),
    .lock_to_data_o(l2d), .freq_locked_o(flk)
  );

  task automatic chk(input bit exp, input string tag);
    n_chk++;
    if (l2d !== exp || flk !== exp) begin
      n_err++;
      $display("FAIL %s: lock_to_data=%b freq_locked=%b expected %b/%b",
               tag, l2d, flk, exp, exp);
    end
  endtask

  task automatic step(input int inc);
    @(negedge clk);
    rec = rec + CW'(inc);
  endtask

  // one window-long stretch at a fixed rate; optional check at cycle 6
  task automatic win(input int inc, input bit chk_en, input bit exp, input string tag);
    for (int i = 0; i < WIN; i++) begin
      step(inc);
      if (chk_en && i == 6) chk(exp, tag);
    end
  endtask

  task automatic do_reset(input int t);
    @(negedge clk);
    rst_n = 1'b0; f_ref = 1'b0; f_data = 1'b0; sig = 1'b1;
    rec = '0; thr = TW'(t);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int thr_list[5] = '{0, 15, 16, 31, 32};
    rst_n = 1'b0; f_ref = 1'b0; f_data = 1'b0; sig = 1'b1; rec = '0; thr = '0;
    repeat (2) @(negedge clk);
    chk(1'b0, "R1 in reset");
    do_reset(8);
    step(MULT);
    chk(1'b0, "R1 after reset");

    // R5/R6 sweep: rate against threshold, boundary at equality
    for (int inc = 0; inc <= 8; inc++) begin
      for (int k = 0; k < 5; k++) begin
        int dev;
        bit ok;
        dev = (inc - MULT) * WIN;
        if (dev < 0) dev = -dev;
        ok = (dev <= thr_list[k]);
        do_reset(thr_list[k]);
        win(inc, 1'b0, 1'b0, "");
        win(inc, 1'b0, 1'b0, "");
        win(inc, 1'b1, 1'b0, "R6 one good window not enough");
        win(inc, 1'b1, ok, "R5 tolerance verdict");
      end
    end

    // R7: bad window inside a good run restarts the count; bad window in data drops
    do_reset(8);
    win(4, 1'b0, 1'b0, "");
    win(4, 1'b0, 1'b0, "");
    win(6, 1'b0, 1'b0, "");
    win(4, 1'b1, 1'b0, "R7 bad window interrupts run");
    win(4, 1'b1, 1'b0, "R7 run restarted after bad window");
    win(6, 1'b1, 1'b1, "R6 two good windows reach data");
    win(4, 1'b1, 1'b0, "R7 bad window leaves data mode");

    // R8: signal loss
    do_reset(8);
    win(4, 1'b0, 1'b0, "");
    win(4, 1'b0, 1'b0, "");
    win(4, 1'b0, 1'b0, "");
    win(4, 1'b1, 1'b1, "R8 locked before loss");
    sig = 1'b0;
    step(4); step(4);
    chk(1'b0, "R8 loss forces reference next cycle");
    win(4, 1'b0, 1'b0, "");
    win(4, 1'b1, 1'b0, "R8 verdicts ignored while signal low");
    sig = 1'b1;
    win(4, 1'b1, 1'b0, "R8 still reference after return");
    win(4, 1'b1, 1'b0, "R8 one good window after return");
    win(4, 1'b1, 1'b1, "R8 relock after two windows");

    // R2/R3/R4: overrides
    f_ref = 1'b1;
    step(4); step(4);
    chk(1'b1, "R2 sync latency, unchanged after two edges");
    step(4);
    chk(1'b0, "R2 forced reference after three edges");
    win(4, 1'b1, 1'b0, "R2 held under good rate");
    win(4, 1'b1, 1'b0, "R2 held under good rate");
    win(4, 1'b1, 1'b0, "R9 flag low in forced reference");
    f_data = 1'b1;
    step(4); step(4);
    chk(1'b0, "R3 sync latency, unchanged after two edges");
    step(4);
    chk(1'b1, "R3 force-data over force-ref");
    sig = 1'b0;
    win(0, 1'b1, 1'b1, "R3 data despite signal loss and bad rate");
    f_ref = 1'b0;
    win(0, 1'b1, 1'b1, "R3 data with force-data alone");
    f_data = 1'b0; sig = 1'b1;
    step(4); step(4);
    chk(1'b1, "R4 release not seen after two edges");
    step(4);
    chk(1'b0, "R4 release restarts in reference");
    win(4, 1'b1, 1'b0, "R4 baseline window");
    win(4, 1'b1, 1'b0, "R4 restart needs fresh windows");
    win(4, 1'b1, 1'b0, "R4 one window after restart");
    win(4, 1'b1, 1'b1, "R4 auto relock after restart");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule